// File: doc/BRIEF.md
# Two-Branch Recursive Convolutional Frame Encoder

This block turns a frame of information bits into a serial coded stream for a turbo-style link. Two identical rate-1/2 recursive systematic constituent coders are used, each with constraint length 3 and a 2-bit state. The recursion uses feedback polynomial 1+D+D^2 and the parity uses feed-forward polynomial 1+D^2 (octal 7/5). The first coder reads the frame in natural order. The second reads it through a permutation held in a read-only table, so the whole frame is stored before any output is produced. At the end of the frame the first coder alone is flushed to the all-zero state.

Bits arrive one per accepted handshake (`in_valid`/`in_ready`) with start and end markers. The coded bits leave one per handshake (`out_valid`/`out_ready`). The controller has four states. IDLE waits for a start marker. IDLE→LOAD happens on a start bit without an end marker; IDLE→ENCODE happens on a start bit that also carries the end marker. LOAD stores bits, and LOAD→ENCODE happens on the end marker or on the bit that fills the frame. ENCODE emits three bits per step, and ENCODE→TAIL happens after the last bit of step N-1. TAIL emits two flush steps of two bits each, and TAIL→IDLE happens after the last of them. A frame therefore yields 3·N+4 output bits.

Top module: `turbo_enc_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In IDLE, a bit offered without `in_sof` is accepted and dropped. It causes no output and does not enter the next frame.
- R3: A start bit begins a frame at position 0, and later bits fill successive positions. Loading ends on `in_eof` or on the N-th bit. From then until the frame's last coded bit, `in_ready` is 0 and `out_valid` is 1.
- R4: In a frame ended early by `in_eof`, every position that was not received encodes as 0. Encoding still runs for all N steps.
- R5: For step k, bits go out in the order systematic, parity 1, parity 2. The systematic bit is frame bit k.
- R6: Parity 1 comes from the first coder. It computes a = u ^ s1 ^ s2 and outputs parity a ^ s2, then takes (s1,s2) ← (a,s1), where u is frame bit k. Its state is zero at the start of every frame.
- R7: Parity 2 uses the same recursion, also starting from zero, on frame bit π(k), where π(k) = (PERM_A·k + PERM_B·k²) mod N.
- R8: After step N-1, two tail steps follow. Each emits the feed-in s1^s2 and then the parity, which equals s2. No parity 2 is sent. The first coder's state is zero afterwards.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_valid` hold.
- R10: After the last tail bit the block returns to IDLE, with `in_ready` 1 and `out_valid` 0, and it encodes the next frame from zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Input bit can be taken |
| in_bit | input | 1 | Information bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| in_eof | input | 1 | Marks the last bit of a frame |
| out_valid | output | 1 | Coded bit available |
| out_ready | input | 1 | Consumer takes the coded bit |
| out_bit | output | 1 | Serial coded bit |

## Verification
The bench uses a 16-bit frame and computes the whole coded stream of each frame arithmetically. It sends all-zero and all-one frames and a single 1 at each of the 16 positions; the impulse responses separate the natural-order parity from the permuted parity at every index. It also sends mixed words, short frames ended early and stray bits before a start marker. It runs each pattern with the consumer always ready and with the consumer stalling, so holding of a stalled bit is told apart from its sequencing.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_ENCODE = 2'd2,
        ST_TAIL   = 2'd3
    } enc_state_t;

    // Quadratic permutation: (a*k + b*k*k) mod n
    function automatic int qpp_index(int k, int a, int b, int n);
        longint lk;
        lk = longint'(k);
        return int'((longint'(a) * lk + longint'(b) * lk * lk) % longint'(n));
    endfunction

endpackage

// File: rtl/rsc_enc.sv
module rsc_enc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic       tail,
    input  logic       din,
    output logic       parity,
    output logic [1:0] state_o
);
    // state_q[1] = most recent register bit (s1), state_q[0] = older (s2)
    logic [1:0] state_q;
    logic       fb;

    always_comb begin
        // in flush mode the input cancels the feedback, so the fed bit is 0
        fb     = tail ? 1'b0 : (din ^ state_q[1] ^ state_q[0]);
        parity = fb ^ state_q[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= 2'b00;
        else if (clear)
            state_q <= 2'b00;
        else if (step)
            state_q <= {fb, state_q[1]};
    end

    assign state_o = state_q;

endmodule

// File: rtl/perm_rom.sv
module perm_rom #(
    parameter int LEN    = 1024,
    parameter int COEF_A = 31,
    parameter int COEF_B = 64,
    localparam int AW    = $clog2(LEN)
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] data
);
    import turbo_enc_pkg::*;

    logic [AW-1:0] table_q [LEN];

    for (genvar i = 0; i < LEN; i++) begin : g_entry
        assign table_q[i] = AW'(qpp_index(i, COEF_A, COEF_B, LEN));
    end

    assign data = table_q[addr];

endmodule

// File: rtl/turbo_enc_top.sv
module turbo_enc_top #(
    parameter int FRAME_LEN = 1024,
    parameter int PERM_A    = 31,
    parameter int PERM_B    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    input  logic in_sof,
    input  logic in_eof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit
);
    import turbo_enc_pkg::*;

    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    enc_state_t state_q, state_d;

    logic [FRAME_LEN-1:0] info_q;
    logic [CNT_W-1:0]     fill_q;
    logic [IDX_W-1:0]     step_q;
    logic [1:0]           phase_q;
    logic                 tail_q;

    logic             accept, fire, clear;
    logic             step1, step2, last_phase;
    logic [IDX_W-1:0] wr_idx, perm_idx;
    logic             u1, u2, p1, p2, feed1;
    logic [1:0]       st1, st2;

    // ---------------- handshake decode ----------------
    assign accept = in_valid && in_ready && (state_q == ST_LOAD || in_sof);
    assign fire   = out_valid && out_ready;
    assign clear  = accept && (state_q == ST_IDLE);
    assign wr_idx = (state_q == ST_IDLE) ? '0 : fill_q[IDX_W-1:0];

    assign last_phase = (state_q == ST_ENCODE) ? (phase_q == 2'd2) : (phase_q == 2'd1);
    assign step2 = fire && (state_q == ST_ENCODE) && (phase_q == 2'd2);
    assign step1 = step2 || (fire && (state_q == ST_TAIL) && (phase_q == 2'd1));

    // ---------------- frame store reads ----------------
    assign u1    = (CNT_W'(step_q)   < fill_q) ? info_q[step_q]   : 1'b0;
    assign u2    = (CNT_W'(perm_idx) < fill_q) ? info_q[perm_idx] : 1'b0;
    assign feed1 = st1[1] ^ st1[0];

    perm_rom #(
        .LEN   (FRAME_LEN),
        .COEF_A(PERM_A),
        .COEF_B(PERM_B)
    ) u_perm (
        .addr(step_q),
        .data(perm_idx)
    );

    rsc_enc u_enc1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step1),
        .tail   (state_q == ST_TAIL),
        .din    (u1),
        .parity (p1),
        .state_o(st1)
    );

    rsc_enc u_enc2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step2),
        .tail   (1'b0),
        .din    (u2),
        .parity (p2),
        .state_o(st2)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept)
                    state_d = (in_eof || FRAME_LEN == 1) ? ST_ENCODE : ST_LOAD;
            ST_LOAD:
                if (accept && (in_eof || fill_q == CNT_W'(FRAME_LEN - 1)))
                    state_d = ST_ENCODE;
            ST_ENCODE:
                if (step2 && step_q == IDX_W'(FRAME_LEN - 1))
                    state_d = ST_TAIL;
            ST_TAIL:
                if (fire && last_phase && tail_q)
                    state_d = ST_IDLE;
        endcase
    end

    // ---------------- counters and frame store ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q  <= '0;
            fill_q  <= '0;
            step_q  <= '0;
            phase_q <= '0;
            tail_q  <= 1'b0;
        end else begin
            if (accept) begin
                info_q[wr_idx] <= in_bit;
                fill_q         <= CNT_W'(wr_idx) + CNT_W'(1);
                step_q         <= '0;
                phase_q        <= '0;
                tail_q         <= 1'b0;
            end else if (fire) begin
                if (!last_phase)
                    phase_q <= phase_q + 2'd1;
                else begin
                    phase_q <= '0;
                    if (state_q == ST_ENCODE)
                        step_q <= step_q + IDX_W'(1);
                    else
                        tail_q <= ~tail_q;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: in_ready = 1'b1;
            ST_ENCODE: begin
                out_valid = 1'b1;
                unique case (phase_q)
                    2'd0:    out_bit = u1;
                    2'd1:    out_bit = p1;
                    default: out_bit = p2;
                endcase
            end
            ST_TAIL: begin
                out_valid = 1'b1;
                out_bit   = (phase_q == 2'd0) ? feed1 : p1;
            end
        endcase
    end

    // ---------------- assertions ----------------
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

    assert_load_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && accept && in_eof) |=> (!in_ready && out_valid));

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(FRAME_LEN));

    assert_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st1 == 2'b00 && st2 == 2'b00));

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && fire && last_phase && tail_q) |=> (st1 == 2'b00));

    assert_back_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && fire && last_phase && tail_q) |=> (in_ready && !out_valid));

endmodule

// File: tb/turbo_enc_top_test.sv
module turbo_enc_top_test;

    localparam int N    = 16;
    localparam int PA   = 3;
    localparam int PB   = 4;
    localparam int OUTN = 3 * N + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_bit;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    turbo_enc_top #(.FRAME_LEN(N), .PERM_A(PA), .PERM_B(PB)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic int perm(input int k);
        return (PA * k + PB * k * k) % N;
    endfunction

    // R5/R6/R7/R8 reference stream
    task automatic build_expected(input logic [N-1:0] data, input int len, output logic exp [OUTN]);
        logic info [N];
        logic a1, b1, a2, b2, f, u;
        a1 = 0; b1 = 0; a2 = 0; b2 = 0;
        for (int k = 0; k < N; k++) info[k] = (k < len) ? data[k] : 1'b0;
        for (int k = 0; k < N; k++) begin
            u = info[k];
            f = u ^ a1 ^ b1;
            exp[3*k]   = u;
            exp[3*k+1] = f ^ b1;
            b1 = a1; a1 = f;
            u = info[perm(k)];
            f = u ^ a2 ^ b2;
            exp[3*k+2] = f ^ b2;
            b2 = a2; a2 = f;
        end
        for (int j = 0; j < 2; j++) begin
            exp[3*N+2*j]   = a1 ^ b1;
            exp[3*N+2*j+1] = b1;
            b1 = a1; a1 = 1'b0;
        end
    endtask

    task automatic run_frame(input logic [N-1:0] data, input int len, input int stall);
        logic exp [OUTN];
        int idx, cyc;
        logic held, pending, r;
        string req;
        build_expected(data, len, exp);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_bit = data[i];
            in_sof = (i == 0); in_eof = (i == len - 1);
            check("R3", in_ready, 1'b1, "ready while loading");
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        check("R3", in_ready, 1'b0, "ready after load");
        check("R3", out_valid, 1'b1, "valid after load");
        idx = 0; cyc = 0; pending = 0; held = 0;
        while (idx < OUTN && cyc < 2000) begin
            r = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
            out_ready = r;
            if (pending) begin
                check("R9", out_valid, 1'b1, "valid held");
                check("R9", out_bit, held, "bit held");
            end
            if (idx < 3 * N) begin
                if (idx % 3 == 0)      req = "R5";
                else if (idx % 3 == 1) req = "R6";
                else                   req = "R7";
            end else req = "R8";
            if (len < N) req = {req, "/R4"};
            if (idx > 0 && idx < OUTN) check("R3", in_ready, 1'b0, "ready during output");
            if (out_valid) begin
                if (r) begin
                    check(req, out_bit, exp[idx], $sformatf("bit %0d", idx));
                    idx++;
                    pending = 0;
                end else begin
                    held = out_bit;
                    pending = 1;
                end
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        out_ready = 0;
        check("R10", in_ready, 1'b1, "ready after tail");
        check("R10", out_valid, 1'b0, "valid after tail");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1", in_ready, 1'b1, "reset ready");
        check("R1", out_valid, 1'b0, "reset valid");

        // R2: stray ones before any start marker
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1; in_bit = 1; in_sof = 0; in_eof = 0;
            @(posedge clk);
            @(negedge clk);
            in_valid = 0;
            check("R2", out_valid, 1'b0, "no output from stray bit");
            check("R2", in_ready, 1'b1, "still idle");
        end
        run_frame('0, N, 0);                 // R2: stray ones must not appear

        run_frame('1, N, 0);
        for (int p = 0; p < N; p++) run_frame(N'(1) << p, N, p % 2);
        run_frame(16'hA5A5, N, 1);
        run_frame(16'h3C71, N, 0);
        run_frame(16'hFFFF, 5, 1);           // R4: early end, rest zero
        run_frame(16'h0001, 1, 0);           // R4: single-bit frame
        run_frame(16'h9E37, N, 1);           // R10: back-to-back frame

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule